// File: doc/BRIEF.md
# Scrolling Remappable Display RAM

This block is the pixel memory behind a dot-matrix display driver. It stores one bit per pixel in a grid of 104 columns by 65 rows. A host writes it one byte at a time. Each byte covers eight vertically stacked pixels of one column, so the rows fall into pages of eight. The host can also read a byte back. The row-scanning logic of the display fetches one whole row per request, naming the common (row driver) it is about to drive.

A start line register sets which RAM row appears on common 0. Vertical scrolling therefore only rewrites that register and moves no data. Two mirror bits act independently. One reverses the order of the segment (column) bits in a scanned row. The other reverses the order of the commons, counted from the start line. Rows that the active commons never reach stay fully readable and writable, so scroll content can be prepared there ahead of time.

Top module: `disp_ram`

## Requirements
- R1: A host write with `wr_page` = p and `wr_col` = c stores `wr_data` bit b into RAM row 8p+b at column c. On page 8 only bit 0 is stored (row 64), and bits 1..7 are dropped.
- R2: A host write with `wr_page` > 8 or `wr_col` > 103 changes no RAM bit.
- R3: A scan request with `scan_com` < NCOM (64) raises `scan_valid` with the row data on the next cycle. A request with `scan_com` >= NCOM leaves `scan_valid` low on the next cycle.
- R4: Without common mirroring, the scanned RAM row is (start + `scan_com`) mod 65. Any start value from 0 to 64 works, including 38h.
- R5: With common mirroring on, the scanned RAM row is (start + 63 - `scan_com`) mod 65.
- R6: Without segment mirroring, `scan_data` bit s is RAM column s. With segment mirroring on, it is RAM column 103-s.
- R7: A host write takes effect before a scan or host read issued in the same cycle: that read returns the newly written bits.
- R8: `cfg_we` loads the start line and both mirror bits together. The load is ignored entirely if `cfg_start` > 64. A load affects requests from the following cycle onward.
- R9: A host read with an in-range page and column raises `rd_valid` on the next cycle. `rd_data` bit b is then row 8p+b of column c, and bits that map to no row read 0. Row 64 lies outside the active commons but can still be read. An out-of-range read leaves `rd_valid` low.
- R10: While reset is asserted and on the cycle after its release, `scan_valid` and `rd_valid` are 0. Reset also clears the start line and both mirror bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_page | input | 4 | Write page (8 rows per page) |
| wr_col | input | 7 | Write column |
| wr_data | input | 8 | Write byte, bit 0 = top row of the page |
| rd_en | input | 1 | Host byte read strobe |
| rd_page | input | 4 | Read page |
| rd_col | input | 7 | Read column |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| cfg_we | input | 1 | Load start line and mirror bits |
| cfg_start | input | 7 | New start line |
| cfg_seg_rev | input | 1 | New segment mirror bit |
| cfg_com_rev | input | 1 | New common mirror bit |
| scan_req | input | 1 | Row fetch request |
| scan_com | input | 7 | Common index to fetch |
| scan_valid | output | 1 | Row data valid |
| scan_data | output | 104 | Row bits in segment order |

## Verification
Some properties are checked on every cycle. Valid flags must follow in-range requests by exactly one cycle and never appear otherwise. The start line register must always hold a legal row. An illegal configuration load must leave it unchanged. The row arithmetic is left to the bench, which runs many scenarios: wraparound with a start of 38h, mirroring of either axis and of both, the lone row on page 8, out-of-range writes that must not alias, and a write landing in the same cycle as a fetch of the same row.

// File: rtl/disp_ram.sv
module disp_ram #(
  parameter int NCOL = 104,
  parameter int NROW = 65,
  parameter int NCOM = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2((NROW+7)/8)-1:0] wr_page,
  input  logic [$clog2(NCOL)-1:0]     wr_col,
  input  logic [7:0]                  wr_data,
  input  logic                        rd_en,
  input  logic [$clog2((NROW+7)/8)-1:0] rd_page,
  input  logic [$clog2(NCOL)-1:0]     rd_col,
  output logic                        rd_valid,
  output logic [7:0]                  rd_data,
  input  logic                        cfg_we,
  input  logic [$clog2(NROW)-1:0]     cfg_start,
  input  logic                        cfg_seg_rev,
  input  logic                        cfg_com_rev,
  input  logic                        scan_req,
  input  logic [$clog2(NROW)-1:0]     scan_com,
  output logic                        scan_valid,
  output logic [NCOL-1:0]             scan_data
);
  localparam int NPAGE = (NROW + 7) / 8;
  localparam int PW    = $clog2(NPAGE);
  localparam int RW    = $clog2(NROW);

  logic [NCOL-1:0] mem [NROW];
  logic [RW-1:0]   start_q;
  logic            seg_rev_q, com_rev_q;

  logic wr_hit, rd_hit, scan_hit, cfg_ok;
  assign wr_hit   = wr_en && (int'(wr_page) < NPAGE) && (int'(wr_col) < NCOL);
  assign rd_hit   = rd_en && (int'(rd_page) < NPAGE) && (int'(rd_col) < NCOL);
  assign scan_hit = scan_req && (int'(scan_com) < NCOM);
  assign cfg_ok   = cfg_we && (int'(cfg_start) < NROW);

  for (genvar gr = 0; gr < NROW; gr++) begin : g_row
    always_ff @(posedge clk)
      if (wr_hit && wr_page == PW'(gr / 8))
        mem[gr][wr_col] <= wr_data[gr % 8];
  end

  logic [RW:0]     com_idx, row_sum;
  logic [RW-1:0]   srow;
  logic [NCOL-1:0] row_bits, scan_next;
  logic [7:0]      rd_next;

  assign com_idx = com_rev_q ? (RW+1)'(NCOM - 1 - int'(scan_com)) : {1'b0, scan_com};
  assign row_sum = {1'b0, start_q} + com_idx;
  assign srow    = (int'(row_sum) >= NROW) ? RW'(int'(row_sum) - NROW) : row_sum[RW-1:0];

  always_comb begin
    row_bits = '0;
    if (int'(srow) < NROW) row_bits = mem[srow];
    if (wr_hit && wr_page == PW'(srow >> 3))
      row_bits[wr_col] = wr_data[srow[2:0]];
    for (int s = 0; s < NCOL; s++)
      scan_next[s] = seg_rev_q ? row_bits[NCOL-1-s] : row_bits[s];
  end

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < 8; b++) begin
      if (int'(rd_page) * 8 + b < NROW && int'(rd_col) < NCOL) begin
        rd_next[b] = mem[int'(rd_page) * 8 + b][rd_col];
        if (wr_hit && wr_page == rd_page && wr_col == rd_col)
          rd_next[b] = wr_data[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q    <= '0;
      seg_rev_q  <= 1'b0;
      com_rev_q  <= 1'b0;
      scan_valid <= 1'b0;
      rd_valid   <= 1'b0;
      scan_data  <= '0;
      rd_data    <= '0;
    end else begin
      if (cfg_ok) begin
        start_q   <= cfg_start;
        seg_rev_q <= cfg_seg_rev;
        com_rev_q <= cfg_com_rev;
      end
      scan_valid <= scan_hit;
      rd_valid   <= rd_hit;
      if (scan_hit) scan_data <= scan_next;
      if (rd_hit)   rd_data   <= rd_next;
    end
  end

  // R3
  scan_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_req && int'(scan_com) < NCOM) |=> scan_valid);
  // R3
  scan_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_req && int'(scan_com) < NCOM) |=> !scan_valid);
  // R9
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(rd_page) < NPAGE && int'(rd_col) < NCOL) |=> rd_valid);
  // R9
  rd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && int'(rd_page) < NPAGE && int'(rd_col) < NCOL) |=> !rd_valid);
  // R8
  start_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(start_q) < NROW);
  // R8
  cfg_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && int'(cfg_start) >= NROW) |=> ($stable(start_q) && $stable(seg_rev_q) && $stable(com_rev_q)));
endmodule

// File: tb/disp_ram_tb.sv
module disp_ram_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, cfg_we = 0, scan_req = 0;
  logic [3:0] wr_page = 0, rd_page = 0;
  logic [6:0] wr_col = 0, rd_col = 0, cfg_start = 0, scan_com = 0;
  logic [7:0] wr_data = 0;
  logic cfg_seg_rev = 0, cfg_com_rev = 0;
  logic rd_valid, scan_valid;
  logic [7:0] rd_data;
  logic [103:0] scan_data;

  disp_ram u_dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  string tag = "R10";
  bit rm [65][104];
  int m_start = 0;
  bit m_seg = 0, m_com = 0;
  bit e_sv = 0, e_rv = 0, armed = 0;
  logic [103:0] e_sd;
  logic [7:0] e_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_sv <= 0; e_rv <= 0; m_start = 0; m_seg = 0; m_com = 0;
    end else begin
      if (wr_en && wr_page <= 8 && wr_col <= 103)
        for (int b = 0; b < 8; b++)
          if (wr_page * 8 + b <= 64) rm[wr_page*8+b][wr_col] = wr_data[b];
      e_sv <= scan_req && scan_com < 64;
      if (scan_req && scan_com < 64) begin
        int row;
        row = (m_start + (m_com ? 63 - scan_com : scan_com)) % 65;
        for (int s = 0; s < 104; s++) e_sd[s] <= rm[row][m_seg ? 103 - s : s];
      end
      e_rv <= rd_en && rd_page <= 8 && rd_col <= 103;
      if (rd_en && rd_page <= 8 && rd_col <= 103)
        for (int b = 0; b < 8; b++)
          e_rd[b] <= (rd_page * 8 + b <= 64) ? rm[rd_page*8+b][rd_col] : 1'b0;
      if (cfg_we && cfg_start <= 64) begin
        m_start = cfg_start; m_seg = cfg_seg_rev; m_com = cfg_com_rev;
      end
    end
  end

  always @(negedge clk) if (armed) begin
    checks++;
    if (scan_valid !== e_sv || rd_valid !== e_rv) begin
      fails++;
      $display("FAIL %s valid: scan %b/%b rd %b/%b (actual/expected)", tag, scan_valid, e_sv, rd_valid, e_rv);
    end
    if (e_sv) begin
      checks++;
      if (scan_data !== e_sd) begin
        fails++;
        $display("FAIL %s scan_data actual %h expected %h", tag, scan_data, e_sd);
      end
    end
    if (e_rv) begin
      checks++;
      if (rd_data !== e_rd) begin
        fails++;
        $display("FAIL %s rd_data actual %h expected %h", tag, rd_data, e_rd);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    wr_en = 0; rd_en = 0; cfg_we = 0; scan_req = 0;
  endtask
  task automatic wr(input int p, input int c, input int d);
    @(negedge clk);
    wr_en = 1; wr_page = 4'(p); wr_col = 7'(c); wr_data = 8'(d);
    rd_en = 0; cfg_we = 0; scan_req = 0;
  endtask
  task automatic rd(input int p, input int c);
    @(negedge clk);
    rd_en = 1; rd_page = 4'(p); rd_col = 7'(c);
    wr_en = 0; cfg_we = 0; scan_req = 0;
  endtask
  task automatic cfg(input int st, input bit sr, input bit cr);
    @(negedge clk);
    cfg_we = 1; cfg_start = 7'(st); cfg_seg_rev = sr; cfg_com_rev = cr;
    wr_en = 0; rd_en = 0; scan_req = 0;
  endtask
  task automatic scan(input int c);
    @(negedge clk);
    scan_req = 1; scan_com = 7'(c);
    wr_en = 0; rd_en = 0; cfg_we = 0;
  endtask
  task automatic scan_all();
    for (int c = 0; c < 64; c++) scan(c);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    armed = 1;
    tag = "R10";
    @(negedge clk); rst_n = 1;
    idle(); idle();
    tag = "R1";
    for (int p = 0; p < 9; p++)
      for (int c = 0; c < 104; c++)
        wr(p, c, (p == 8) ? 8'hFF : ((p * 29 + c * 7 + 3) & 255));
    idle();
    tag = "R9";
    rd(0, 0); rd(3, 50); rd(7, 103); rd(8, 17); rd(8, 103); idle();
    rd(9, 0); rd(2, 104); rd(15, 127); idle();
    tag = "R2";
    wr(9, 5, 8'h00); wr(3, 104, 8'h00); wr(15, 127, 8'h00); wr(2, 110, 8'hAA); idle();
    rd(1, 5); rd(3, 0); rd(8, 5); rd(2, 103); idle();
    tag = "R4";
    scan_all();
    tag = "R3";
    scan(64); scan(100); scan(127); scan(63); idle();
    tag = "R4";
    cfg(8'h38, 0, 0); scan(0); scan_all();
    cfg(64, 0, 0); scan_all();
    tag = "R5";
    cfg(0, 0, 1); scan_all();
    cfg(8'h38, 0, 1); scan_all();
    tag = "R6";
    cfg(10, 1, 0); scan_all();
    cfg(8'h38, 1, 1); scan_all();
    tag = "R8";
    cfg(70, 0, 0); scan(0); scan(20); cfg(127, 0, 0); scan(5); idle();
    cfg(3, 0, 0); scan(1);
    @(negedge clk); scan_req = 1; scan_com = 2; cfg_we = 1; cfg_start = 20;
    idle(); scan(2); idle();
    tag = "R7";
    @(negedge clk);
    cfg_we = 0; rd_en = 1; rd_page = 4; rd_col = 9;
    wr_en = 1; wr_page = 4; wr_col = 9; wr_data = 8'h5A;
    scan_req = 1; scan_com = 7'(34 - 3 + 65 - 20 - 20 + 8);
    idle();
    cfg(0, 0, 0);
    @(negedge clk);
    cfg_we = 0; rd_en = 0;
    wr_en = 1; wr_page = 8; wr_col = 0; wr_data = 8'h00;
    scan_req = 1; scan_com = 0;
    idle();
    @(negedge clk);
    wr_en = 1; wr_page = 0; wr_col = 77; wr_data = 8'h01;
    scan_req = 1; scan_com = 0; rd_en = 1; rd_page = 0; rd_col = 77;
    idle();
    tag = "R1";
    cfg(1, 0, 0); scan(63); rd(8, 0); rd(8, 1); idle();
    tag = "R10";
    @(negedge clk); rst_n = 0; scan_req = 1; scan_com = 0; rd_en = 1; rd_page = 0; rd_col = 0;
    @(negedge clk); rst_n = 1; scan_req = 0; rd_en = 0;
    idle();
    scan(0); idle();
    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule